// File: doc/BRIEF.md
# Target-Compare Timer Channel

This block is a single 16-bit up-counting timer with a programmable compare value. Three clock sources are available: the system clock, a prescaled clock that gives one count per eight system clocks, and a tick-enable input driven from outside. The count either returns to zero when it reaches the compare value or runs on to 0xFFFF and wraps.

Compare matches and wraps set sticky flags in the mode register. They can also raise a single-cycle interrupt pulse. The pulse fires either once per arming or on every event. Writing the mode register re-arms the one-shot pulse.

Software reaches the channel through a simple synchronous port that has a write strobe, a read strobe and a 2-bit register select:
- select 0 is the counter;
- select 1 is the mode register;
- select 2 is the compare value.

Read data appears on the cycle after the read strobe. Reading the mode register clears both event flags. Several channels, with their shared decode and interrupt collection, are built from instances of this block.

Top module: `tmr_channel`

## Requirements
- R1: A write to select 0 loads the counter with the low 16 bits of `wdata`. Any higher bits are discarded.
- R2: A write to select 1 does four things: it stores `wdata[15:0]` as the mode, sets the count to 0, restarts the prescaler, and re-arms the one-shot interrupt.
- R3: The clock source is chosen by mode bits 8 and 9. Bit 8 set: the count advances on each clock with `ext_tick` high, and bit 9 is ignored. Only bit 9 set: the count advances once per 8 clocks, first on the 8th clock after a mode write. Neither bit set: the count advances every clock.
- R4: While mode bit 0 is set, the count does not advance.
- R5: A count step whose result equals the compare value is a target event. With mode bit 3 set, a target event sets the count to 0 instead. With bit 3 clear, the count passes the compare value and continues.
- R6: A step from 0xFFFF wraps the count to 0 and is an overflow event. It sets mode bit 12 and requests an interrupt if mode bit 5 is set.
- R7: A target event sets mode bit 11 and requests an interrupt if mode bit 4 is set.
- R8: With mode bit 6 set, every request produces a pulse. With bit 6 clear, only the first request after a mode write produces one.
- R9: Every target or overflow event sets mode bit 10. Bit 10 stays set until the next mode write.
- R10: A mode read returns the current mode and then clears bits 11 and 12. Bit 10 is kept. An event in the same cycle as the read leaves its flag set.
- R11: A write to select 2 changes the compare value and leaves the count unchanged. Later compares use the new value.
- R12: No count step and no event occurs in a cycle with a write. A written counter value reads back from the next cycle on. Read data for any select appears one cycle after the read strobe.
- R13: `irq` is a one-cycle pulse in the cycle after the clock edge at which the requesting event happened.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick | input | 1 | External count enable, used when mode bit 8 is set |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 counter, 1 mode, 2 compare |
| wdata | input | 32 | Write data |
| rdata | output | 16 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt request pulse |

## Verification
A wrong prescaler phase or a missing hold during writes shows up in a counter readback taken a known number of cycles after a mode write. It appears as an error of one or more counts on the very next read. A faulty compare or wrap shows up in two ways: the count fails to return to zero, and the wrong flags appear in the mode word at the following mode read. Errors in the one-shot state appear as an extra or a missing `irq` pulse within a counting window that is a few compare periods long. Errors in flag clearing appear on the second of two back-to-back mode reads.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int MODE_W     = 16;
   localparam int MB_STOP    = 0;
   localparam int MB_ZERO_AT = 3;
   localparam int MB_IRQ_HIT = 4;
   localparam int MB_IRQ_WRP = 5;
   localparam int MB_REPEAT  = 6;
   localparam int MB_EXT     = 8;
   localparam int MB_DIV     = 9;
   localparam int MB_ANY_EVT = 10;
   localparam int MB_HIT     = 11;
   localparam int MB_WRAP    = 12;

   localparam logic [MODE_W-1:0] FLAG_KEEP_MASK =
      ~((MODE_W'(1) << MB_HIT) | (MODE_W'(1) << MB_WRAP));

   typedef enum logic [1:0] {
      SEL_COUNT  = 2'd0,
      SEL_MODE   = 2'd1,
      SEL_TARGET = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/tmr_rate_gen.sv
module tmr_rate_gen #(
   parameter int DIV_LOG2 = 3,
   parameter bit HAS_EXT  = 1'b1,
   parameter bit HAS_DIV  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic ext_sel,
   input  logic div_sel,
   input  logic ext_tick,
   output logic tick
);
   logic div_path;

   generate
      if (HAS_DIV) begin : g_div
         logic [DIV_LOG2-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       div_q <= '0;
            else if (restart) div_q <= '0;
            else              div_q <= div_q + 1'b1;
         end
         assign div_path = div_sel ? (&div_q) : 1'b1;

         AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> (div_q == '0)); // R3
      end else begin : g_nodiv
         logic unused_div;
         assign unused_div = div_sel ^ restart;
         assign div_path   = 1'b1;
      end

      if (HAS_EXT) begin : g_ext
         assign tick = ext_sel ? ext_tick : div_path;
      end else begin : g_noext
         logic unused_ext;
         assign unused_ext = ext_sel ^ ext_tick;
         assign tick       = div_path;
      end
   endgenerate
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             hold,
   input  logic             zero_at_hit,
   input  logic [CNT_W-1:0] target,
   input  logic             ld_en,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt,
   output logic             hit_evt,
   output logic             wrap_evt
);
   logic             step;
   logic [CNT_W-1:0] cnt_inc;
   logic             reach;

   assign step     = tick & run & ~hold;
   assign cnt_inc  = cnt + 1'b1;
   assign reach    = (cnt_inc == target);
   assign hit_evt  = step & reach;
   assign wrap_evt = step & (&cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (ld_en)                cnt <= ld_val;
      else if (step) begin
         if (reach && zero_at_hit)   cnt <= '0;
         else                        cnt <= cnt_inc;
      end
   end

   AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> (cnt == $past(ld_val))); // R1
   AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ld_en) |=> $stable(cnt)); // R4
   AST_WRITE_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> (!hit_evt && !wrap_evt)); // R12
endmodule

// File: rtl/tmr_irq_gen.sv
module tmr_irq_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic rearm,
   input  logic hit_evt,
   input  logic wrap_evt,
   input  logic irq_on_hit,
   input  logic irq_on_wrap,
   input  logic repeat_en,
   output logic irq
);
   logic fired_q;
   logic want;
   logic allow;

   assign want  = (hit_evt & irq_on_hit) | (wrap_evt & irq_on_wrap);
   assign allow = repeat_en | ~fired_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fired_q <= 1'b0;
         irq     <= 1'b0;
      end else begin
         irq <= want & allow;
         if (rearm)              fired_q <= 1'b0;
         else if (want && allow) fired_q <= 1'b1;
      end
   end

   AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (fired_q && !repeat_en && !rearm) |=> !irq); // R8
   AST_REARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      rearm |=> !fired_q); // R2
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
   parameter int CNT_W    = 16,
   parameter int BUS_W    = 32,
   parameter int DIV_LOG2 = 3,
   parameter bit HAS_EXT  = 1'b1,
   parameter bit HAS_DIV  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_tick,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [1:0]       addr,
   input  logic [BUS_W-1:0] wdata,
   output logic [15:0]      rdata,
   output logic             irq
);
   import tmr_pkg::*;

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("tmr_channel: CNT_W must lie in 2..16");
      end
      if (BUS_W < MODE_W) begin : g_bad_bus
         $error("tmr_channel: BUS_W must be at least 16");
      end
      if (DIV_LOG2 < 1 || DIV_LOG2 > 8) begin : g_bad_div
         $error("tmr_channel: DIV_LOG2 must lie in 1..8");
      end
   endgenerate

   reg_sel_e          sel;
   logic              wr_cnt, wr_mode, wr_tgt, rd_mode;
   logic [MODE_W-1:0] mode_q, mode_d;
   logic [CNT_W-1:0]  target_q;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  ld_val;
   logic              tick, hit_evt, wrap_evt;
   logic              unused_wdata;

   assign sel          = reg_sel_e'(addr);
   assign wr_cnt       = wr_en && (sel == SEL_COUNT);
   assign wr_mode      = wr_en && (sel == SEL_MODE);
   assign wr_tgt       = wr_en && (sel == SEL_TARGET);
   assign rd_mode      = rd_en && (sel == SEL_MODE);
   assign ld_val       = wr_cnt ? wdata[CNT_W-1:0] : '0;
   assign unused_wdata = ^wdata;

   tmr_rate_gen #(
      .DIV_LOG2 (DIV_LOG2),
      .HAS_EXT  (HAS_EXT),
      .HAS_DIV  (HAS_DIV)
   ) i_rate (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (wr_mode),
      .ext_sel  (mode_q[MB_EXT]),
      .div_sel  (mode_q[MB_DIV]),
      .ext_tick (ext_tick),
      .tick     (tick)
   );

   tmr_count_core #(
      .CNT_W (CNT_W)
   ) i_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .run         (~mode_q[MB_STOP]),
      .hold        (wr_en),
      .zero_at_hit (mode_q[MB_ZERO_AT]),
      .target      (target_q),
      .ld_en       (wr_cnt | wr_mode),
      .ld_val      (ld_val),
      .cnt         (cnt),
      .hit_evt     (hit_evt),
      .wrap_evt    (wrap_evt)
   );

   tmr_irq_gen i_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .rearm       (wr_mode),
      .hit_evt     (hit_evt),
      .wrap_evt    (wrap_evt),
      .irq_on_hit  (mode_q[MB_IRQ_HIT]),
      .irq_on_wrap (mode_q[MB_IRQ_WRP]),
      .repeat_en   (mode_q[MB_REPEAT]),
      .irq         (irq)
   );

   always_comb begin
      mode_d = mode_q;
      if (rd_mode) mode_d = mode_d & FLAG_KEEP_MASK;
      if (hit_evt) begin
         mode_d[MB_HIT]     = 1'b1;
         mode_d[MB_ANY_EVT] = 1'b1;
      end
      if (wrap_evt) begin
         mode_d[MB_WRAP]    = 1'b1;
         mode_d[MB_ANY_EVT] = 1'b1;
      end
      if (wr_mode) mode_d = wdata[MODE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '0;
         target_q <= '0;
         rdata    <= '0;
      end else begin
         mode_q <= mode_d;
         if (wr_tgt) target_q <= wdata[CNT_W-1:0];
         if (rd_en) begin
            unique case (sel)
               SEL_COUNT:  rdata <= 16'(cnt);
               SEL_MODE:   rdata <= mode_q;
               SEL_TARGET: rdata <= 16'(target_q);
               default:    rdata <= '0;
            endcase
         end
      end
   end

   AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mode |=> (cnt == '0)); // R2
   AST_TARGET_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_tgt |=> (cnt == $past(cnt))); // R11
   AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_mode && !wr_en && !hit_evt && !wrap_evt) |=>
      (!mode_q[MB_HIT] && !mode_q[MB_WRAP])); // R10
   AST_EVENT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_evt || wrap_evt) |=> mode_q[MB_ANY_EVT]); // R9
   AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt |=> (mode_q[MB_WRAP] && cnt == '0)); // R6
   AST_HIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      hit_evt |=> mode_q[MB_HIT]); // R7
endmodule

// File: tb/test_tmr_channel.sv
`timescale 1ns/100ps
module test_tmr_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = 32'd0;
   logic [15:0] rdata;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;
   int irq_seen = 0;
   bit done = 1'b0;

   localparam logic [1:0] A_CNT = 2'd0, A_MODE = 2'd1, A_TGT = 2'd2;

   tmr_channel i_tmr_channel (
      .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .wr_en(wr_en),
      .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   always #2.5 clk = ~clk;

   always @(negedge clk) if (irq === 1'b1) irq_seen++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [1:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rreg(input logic [1:0] a, output logic [15:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      #1 d = rdata;
   endtask

   task automatic arm();
      #1 irq_seen = 0;
   endtask

   task automatic idle(input int m);
      repeat (m) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      int ms_free[6] = '{0, 1, 2, 5, 13, 40};
      int ms_div[7]  = '{0, 7, 8, 9, 63, 64, 100};
      int ms_ext[4]  = '{1, 4, 9, 10};
      int tgts[3]    = '{1, 3, 7};

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk("reset irq", {31'd0, irq}, 32'd0);
      rreg(A_MODE, v); chk("reset mode", {16'd0, v}, 32'd0);
      rreg(A_TGT, v);  chk("reset target", {16'd0, v}, 32'd0);

      // R3 every clock, R2 restart from zero
      foreach (ms_free[i]) begin
         wreg(A_MODE, 32'h0); arm(); idle(ms_free[i]);
         rreg(A_CNT, v);
         chk("R3 every-clock count / R2 restart", {16'd0, v}, 32'(ms_free[i]));
      end

      // R3 divide by 8, prescaler restarted by mode write (R2)
      foreach (ms_div[i]) begin
         wreg(A_MODE, 32'h200); arm(); idle(ms_div[i]);
         rreg(A_CNT, v);
         chk("R3 divide-by-8 count", {16'd0, v}, 32'(ms_div[i] / 8));
      end

      // R3 external tick, bit 8 wins over bit 9 on odd iterations
      foreach (ms_ext[i]) begin
         wreg(A_MODE, (i % 2 == 1) ? 32'h300 : 32'h100); arm();
         for (int j = 0; j < ms_ext[i]; j++) begin
            ext_tick = (j % 3 == 0);
            @(negedge clk);
         end
         ext_tick = 1'b0;
         rreg(A_CNT, v);
         chk("R3 external tick count", {16'd0, v}, 32'((ms_ext[i] + 2) / 3));
      end

      // R4 disable bit
      wreg(A_MODE, 32'h1); arm(); idle(30);
      rreg(A_CNT, v);
      chk("R4 stopped count", {16'd0, v}, 32'd0);

      // R5 zero at target, R7 hit flag, R8 repeat vs one-shot, R13 pulses
      foreach (tgts[i]) begin
         for (int rep = 0; rep < 2; rep++) begin
            int t = tgts[i];
            int exp_irq;
            wreg(A_TGT, 32'(t));
            wreg(A_MODE, 32'h18 | (rep ? 32'h40 : 32'h0)); arm(); idle(20);
            rreg(A_CNT, v);
            chk("R5 count modulo target", {16'd0, v}, 32'(20 % t));
            exp_irq = rep ? (21 / t) : ((21 / t) > 0 ? 1 : 0);
            chk(rep ? "R8 R13 repeat pulses" : "R8 R13 one-shot pulse", 32'(irq_seen), 32'(exp_irq));
            rreg(A_MODE, v);
            chk("R7 R9 hit flags", {16'd0, v}, 32'h0C18 | (rep ? 32'h40 : 32'h0));
         end
      end

      // R5 no zeroing: count passes the target; R10 flag clear on read
      wreg(A_TGT, 32'd10);
      wreg(A_MODE, 32'h10); arm(); idle(25);
      rreg(A_CNT, v);
      chk("R5 count runs past target", {16'd0, v}, 32'd25);
      chk("R7 single hit irq", 32'(irq_seen), 32'd1);
      rreg(A_MODE, v);
      chk("R10 first mode read", {16'd0, v}, 32'h0C10);
      rreg(A_MODE, v);
      chk("R10 second mode read flags cleared", {16'd0, v}, 32'h0410);

      // R1 truncation, R6 wrap + overflow irq
      wreg(A_TGT, 32'h1234);
      wreg(A_MODE, 32'h20);
      wreg(A_CNT, 32'h1FFFA); arm(); idle(10);
      rreg(A_CNT, v);
      chk("R1 R6 truncated load then wrap", {16'd0, v}, 32'd4);
      chk("R6 overflow irq", 32'(irq_seen), 32'd1);
      rreg(A_MODE, v);
      chk("R6 R9 wrap flags", {16'd0, v}, 32'h1420);
      rreg(A_MODE, v);
      chk("R10 wrap flag cleared", {16'd0, v}, 32'h0420);

      // R12 write wins over a pending wrap
      wreg(A_MODE, 32'h20);
      wreg(A_CNT, 32'hFFFF);
      wreg(A_CNT, 32'h0050); arm();
      rreg(A_CNT, v);
      chk("R12 written value read next cycle", {16'd0, v}, 32'h50);
      chk("R12 no event in write cycle", 32'(irq_seen), 32'd0);
      rreg(A_MODE, v);
      chk("R12 no wrap flag", {16'd0, v}, 32'h0020);

      // R11 target write keeps count, new target used
      wreg(A_TGT, 32'd100);
      wreg(A_MODE, 32'h8); arm(); idle(20);
      wreg(A_TGT, 32'd30); idle(4);
      rreg(A_CNT, v);
      chk("R11 count kept over target write", {16'd0, v}, 32'd24);
      rreg(A_TGT, v);
      chk("R11 R12 target readback", {16'd0, v}, 32'd30);
      idle(3);
      rreg(A_CNT, v);
      chk("R11 count before new target", {16'd0, v}, 32'd29);
      rreg(A_CNT, v);
      chk("R5 R11 zero at new target", {16'd0, v}, 32'd0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule